// File: doc/BRIEF.md
# Presettable Cascadable Synchronous Counter

A small up-counter with a four-bit state that advances on the rising clock edge. It can be preset from a parallel data input and cleared by an active-low clear. Two count enables let a wide counter be built from several narrow ones. The shared count enable (`cnt_en`) goes to every stage. The trickle enable (`carry_in`) comes from the previous stage's terminal-count flag. Only the trickle enable gates the terminal-count output, so the carry path through a chain is a simple AND chain.

Two elaboration-time parameters select the variant. `ASYNC_CLR` chooses between a clear that acts at once and a clear that is sampled on the clock edge. `DECADE` chooses between a modulo-16 binary sequence and a modulo-10 decade sequence. In the decade sequence, states 10 to 15 fall back into the normal range after one count.

Top module: `preset_counter`

## Requirements
- R1: With `ASYNC_CLR`=1, `clr_n` low forces `q` to 0 at once, with no clock edge needed.
- R2: With `ASYNC_CLR`=0, `clr_n` low leaves `q` unchanged until the next rising edge, which sets `q` to 0.
- R3: Clear wins over preset and counting, whatever the levels of `load_n`, `cnt_en` and `carry_in`.
- R4: At a rising edge with `clr_n` high and `load_n` low, `q` takes `din` (bit 0 to `q[0]`), whatever the levels of both count enables.
- R5: At a rising edge with `clr_n`, `load_n`, `cnt_en` and `carry_in` all high, `q` advances by one step of the selected sequence.
- R6: If `cnt_en` or `carry_in` is low while `load_n` and `clr_n` are high, `q` holds its value.
- R7: In binary mode (`DECADE`=0), `q` wraps from 15 to 0, and `tc` is high exactly when `carry_in` is high and `q` is 15.
- R8: In decade mode (`DECADE`=1), `q` wraps from 9 to 0, and `tc` is high exactly when `carry_in` is high and `q` is 9.
- R9: In decade mode, one count from any state from 10 to 15 gives state 0.
- R10: `tc` does not depend on `cnt_en` or `load_n`.
- R11: A chain with stage 0 `carry_in` tied high, each later stage's `carry_in` driven by the previous stage's `tc`, and a shared `cnt_en` counts modulo 16^N in binary mode, or 10^N in decade mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; immediate or edge-sampled, set by `ASYNC_CLR` |
| load_n | input | 1 | Active-low parallel preset enable |
| din | input | WIDTH | Preset data |
| cnt_en | input | 1 | Shared count enable; does not affect `tc` |
| carry_in | input | 1 | Trickle enable; gates `tc` |
| q | output | WIDTH | Counter state |
| tc | output | 1 | Terminal-count flag |

## Verification
All four parameter combinations are driven in parallel from the same inputs, so one stimulus shows how the clear styles and the two moduli differ. A clear that drops mid-cycle separates immediate clears from edge-sampled ones. Long free counting exposes both wrap points. Presets to 9 and 15 with the shared enable low show that `tc` follows only the trickle enable and the state. Presets to each of 10..15 followed by one count exercise decade recovery. Binary and decade chains then confirm that carries pass correctly across stage boundaries.

// File: rtl/pc_pkg.sv
package pc_pkg;

  // Highest state of the selected sequence.
  function automatic int unsigned pc_top(int unsigned width, bit decade);
    return decade ? 32'd9 : ((32'd1 << width) - 32'd1);
  endfunction

  // One count step; any state at or beyond the top falls back to zero.
  function automatic int unsigned pc_step(int unsigned cur, int unsigned top);
    return (cur >= top) ? 32'd0 : cur + 32'd1;
  endfunction

  function automatic bit pc_is_top(int unsigned cur, int unsigned top);
    return cur == top;
  endfunction

endpackage

// File: rtl/pc_step_logic.sv
module pc_step_logic #(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b0
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             cnt_en,
  input  logic             carry_in,
  output logic [WIDTH-1:0] nxt,
  output logic             load_ev,
  output logic             step_ev
);
  localparam int unsigned TOP = pc_pkg::pc_top(WIDTH, DECADE);

  always_comb begin
    load_ev = !load_n;
    step_ev = load_n && cnt_en && carry_in;
    nxt     = cur;
    if (load_ev) begin
      nxt = din;
    end else if (step_ev) begin
      nxt = WIDTH'(pc_pkg::pc_step(32'(cur), TOP));
    end
  end
endmodule

// File: rtl/pc_state_reg.sv
module pc_state_reg #(
  parameter int unsigned WIDTH     = 4,
  parameter bit          ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);
  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/pc_terminal.sv
module pc_terminal #(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b0
) (
  input  logic [WIDTH-1:0] q,
  input  logic             carry_in,
  output logic             tc
);
  localparam int unsigned TOP = pc_pkg::pc_top(WIDTH, DECADE);

  assign tc = carry_in && pc_pkg::pc_is_top(32'(q), TOP);
endmodule

// File: rtl/preset_counter.sv
module preset_counter #(
  parameter int unsigned WIDTH     = 4,
  parameter bit          ASYNC_CLR = 1'b1,
  parameter bit          DECADE    = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             cnt_en,
  input  logic             carry_in,
  output logic [WIDTH-1:0] q,
  output logic             tc
);
  logic [WIDTH-1:0] nxt;
  logic             load_ev;
  logic             step_ev;

  pc_step_logic #(.WIDTH(WIDTH), .DECADE(DECADE)) u_step (
    .cur      (q),
    .load_n   (load_n),
    .din      (din),
    .cnt_en   (cnt_en),
    .carry_in (carry_in),
    .nxt      (nxt),
    .load_ev  (load_ev),
    .step_ev  (step_ev)
  );

  pc_state_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .nxt   (nxt),
    .q     (q)
  );

  pc_terminal #(.WIDTH(WIDTH), .DECADE(DECADE)) u_tc (
    .q        (q),
    .carry_in (carry_in),
    .tc       (tc)
  );
endmodule

// File: rtl/pc_chk.sv
module pc_chk #(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b0
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic [WIDTH-1:0] din,
  input logic             cnt_en,
  input logic             carry_in,
  input logic [WIDTH-1:0] q,
  input logic             tc,
  input logic             load_ev,
  input logic             step_ev
);
  localparam logic [WIDTH-1:0] TOP_V = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  p_clear_zero_r3: assert property (@(posedge clk)
    !clr_n |=> (q == '0));

  p_load_r4: assert property (@(posedge clk) disable iff (!clr_n)
    load_ev |=> (q == $past(din)));

  p_step_r5: assert property (@(posedge clk) disable iff (!clr_n)
    step_ev |=> (q == (($past(q) >= TOP_V) ? '0 : $past(q) + 1'b1)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(cnt_en && carry_in)) |=> $stable(q));

  p_tc_gate_r10: assert property (@(posedge clk) disable iff (!clr_n)
    tc |-> (carry_in && q == TOP_V));

  p_wrap_r7: assert property (@(posedge clk) disable iff (!clr_n)
    (tc && step_ev) |=> (q == '0));
endmodule

bind preset_counter pc_chk #(.WIDTH(WIDTH), .DECADE(DECADE)) u_chk (
  .clk      (clk),
  .clr_n    (clr_n),
  .load_n   (load_n),
  .din      (din),
  .cnt_en   (cnt_en),
  .carry_in (carry_in),
  .q        (q),
  .tc       (tc),
  .load_ev  (load_ev),
  .step_ev  (step_ev)
);

// File: tb/test_preset_counter.sv
module test_preset_counter;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic       clr_n, load_n, cnt_en, carry_in, ch_en;
  logic [3:0] din;
  logic [3:0] dq [4];
  logic       dtc [4];
  int         mq [4];
  int         tests = 0;
  int         fails = 0;

  // Variant v: bit 0 = immediate clear, bit 1 = decade sequence.
  // Instance i_preset_counter with v=1 uses the default parameters.
  for (genvar v = 0; v < 4; v++) begin : g_var
    preset_counter #(.WIDTH(4), .ASYNC_CLR((v & 1) != 0), .DECADE((v & 2) != 0)) i_preset_counter (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
      .cnt_en(cnt_en), .carry_in(carry_in), .q(dq[v]), .tc(dtc[v]));
  end

  // R11 chains: three binary stages, two decade stages.
  logic [3:0] bq [3];
  logic       btc [3];
  for (genvar k = 0; k < 3; k++) begin : g_bin
    preset_counter #(.WIDTH(4), .ASYNC_CLR(1'b0), .DECADE(1'b0)) i_preset_counter (
      .clk(clk), .clr_n(clr_n), .load_n(1'b1), .din(4'd0), .cnt_en(ch_en),
      .carry_in((k == 0) ? 1'b1 : btc[(k == 0) ? 0 : k-1]), .q(bq[k]), .tc(btc[k]));
  end
  logic [3:0] cq [2];
  logic       ctc [2];
  for (genvar k = 0; k < 2; k++) begin : g_dec
    preset_counter #(.WIDTH(4), .ASYNC_CLR(1'b1), .DECADE(1'b1)) i_preset_counter (
      .clk(clk), .clr_n(clr_n), .load_n(1'b1), .din(4'd0), .cnt_en(ch_en),
      .carry_in((k == 0) ? 1'b1 : ctc[0]), .q(cq[k]), .tc(ctc[k]));
  end

  function automatic bit is_dec(int v);
    return v >= 2;
  endfunction

  function automatic int f_next(int v, int m);
    if (is_dec(v)) return (m < 9) ? m + 1 : 0;
    return (m + 1) % 16;
  endfunction

  function automatic bit f_tc(int v, int m);
    return carry_in && (is_dec(v) ? (m == 9) : (m == 15));
  endfunction

  task automatic cycle();
    int e [4];
    for (int v = 0; v < 4; v++) begin
      if (!clr_n)                  e[v] = 0;
      else if (!load_n)            e[v] = int'(din);
      else if (cnt_en && carry_in) e[v] = f_next(v, mq[v]);
      else                         e[v] = mq[v];
    end
    @(posedge clk);
    @(negedge clk);
    for (int v = 0; v < 4; v++) mq[v] = e[v];
  endtask

  task automatic check_all(string req);
    for (int v = 0; v < 4; v++) begin
      tests++;
      if (int'(dq[v]) != mq[v] || dtc[v] != f_tc(v, mq[v])) begin
        fails++;
        $display("FAIL %s variant %0d: q=%0d tc=%0b expected q=%0d tc=%0b",
                 req, v, dq[v], dtc[v], mq[v], f_tc(v, mq[v]));
      end
    end
  endtask

  task automatic t_reset();
    clr_n = 1'b0; load_n = 1'b1; cnt_en = 1'b0; carry_in = 1'b0; din = 4'd0; ch_en = 1'b0;
    for (int v = 0; v < 4; v++) mq[v] = 0;
    @(negedge clk);
    cycle();
    check_all("R1 R2 reset");
    clr_n = 1'b1;
  endtask

  task automatic t_clear_styles();
    load_n = 1'b0; din = 4'd7;
    cycle();
    load_n = 1'b1;
    check_all("R4 preload");
    #2 clr_n = 1'b0;
    #1;
    mq[1] = 0; mq[3] = 0;        // immediate clear variants only
    check_all("R1 R2 mid-cycle clear");
    @(negedge clk);
    cycle();
    check_all("R2 clear at edge");
    load_n = 1'b0; din = 4'd12; cnt_en = 1'b1; carry_in = 1'b1;
    cycle();
    check_all("R3 clear over load and count");
    load_n = 1'b1;
    cycle();
    check_all("R3 clear over count");
    clr_n = 1'b1; cnt_en = 1'b0; carry_in = 1'b0;
  endtask

  task automatic t_load();
    load_n = 1'b0; din = 4'd5; cnt_en = 1'b0; carry_in = 1'b0;
    cycle();
    check_all("R4 load enables low");
    din = 4'd3; cnt_en = 1'b1; carry_in = 1'b1;
    cycle();
    check_all("R4 load enables high");
    load_n = 1'b1; cnt_en = 1'b0; carry_in = 1'b0;
  endtask

  task automatic t_count();
    clr_n = 1'b0;
    cycle();
    clr_n = 1'b1; cnt_en = 1'b1; carry_in = 1'b1;
    for (int i = 0; i < 22; i++) begin
      cycle();
      check_all("R5 R7 R8 counting");
    end
  endtask

  task automatic t_hold();
    cnt_en = 1'b0; carry_in = 1'b1;
    for (int i = 0; i < 3; i++) begin
      cycle();
      check_all("R6 hold cnt_en low");
    end
    cnt_en = 1'b1; carry_in = 1'b0;
    for (int i = 0; i < 3; i++) begin
      cycle();
      check_all("R6 hold carry_in low");
    end
  endtask

  task automatic t_tc();
    load_n = 1'b0; din = 4'd15; cnt_en = 1'b0; carry_in = 1'b1;
    cycle();
    load_n = 1'b1;
    #1 check_all("R10 R7 tc at 15 with cnt_en low");
    load_n = 1'b0;
    #1 check_all("R10 tc with load_n low");
    @(negedge clk);
    din = 4'd9;
    cycle();
    load_n = 1'b1;
    #1 check_all("R10 R8 tc at 9 with cnt_en low");
    carry_in = 1'b0;
    #1 check_all("R10 tc gated by carry_in");
    @(negedge clk);
  endtask

  task automatic t_recover();
    for (int val = 10; val < 16; val++) begin
      load_n = 1'b0; din = 4'(val); cnt_en = 1'b0; carry_in = 1'b0;
      cycle();
      load_n = 1'b1; cnt_en = 1'b1; carry_in = 1'b1;
      cycle();
      check_all("R9 recovery from 10..15");
    end
    cnt_en = 1'b0; carry_in = 1'b0;
  endtask

  task automatic t_chain();
    int bexp, cexp, bact, cact;
    clr_n = 1'b0; ch_en = 1'b0;
    cycle();
    clr_n = 1'b1; ch_en = 1'b1;
    for (int n = 1; n <= 4200; n++) begin
      @(posedge clk);
      @(negedge clk);
      bexp = n % 4096;
      cexp = n % 100;
      bact = int'(bq[0]) + 16 * int'(bq[1]) + 256 * int'(bq[2]);
      cact = int'(cq[0]) + 10 * int'(cq[1]);
      tests++;
      if (bact != bexp || cact != cexp) begin
        fails++;
        $display("FAIL R11 chain step %0d: bin=%0d dec=%0d expected bin=%0d dec=%0d",
                 n, bact, cact, bexp, cexp);
      end
    end
    ch_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    tests++;
    bact = int'(bq[0]) + 16 * int'(bq[1]) + 256 * int'(bq[2]);
    if (bact != 4200 % 4096) begin
      fails++;
      $display("FAIL R11 chain hold: bin=%0d expected %0d", bact, 4200 % 4096);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_clear_styles();
    t_load();
    t_count();
    t_hold();
    t_tc();
    t_recover();
    t_chain();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule